// File: doc/BRIEF.md
# Reservation Station Bank with Result-Bus Snooping

This block is a small pool of waiting slots that sits in front of one class of functional unit in an out-of-order core. The rename stage hands it an operation. For each of the two source operands it gives either a value or the tag of the slot that will produce that value. The block places the operation in a free slot and returns that slot's tag, so the rename stage can record it as the new owner of the destination register. When every slot is occupied, the block raises a full flag and refuses the issue, and the operation stalls upstream.

Every slot watches one shared result bus, which carries a valid bit, a tag and a value. A waiting operand whose producer tag matches the bus takes the value and clears its tag. A slot whose two tags are both null may be dispatched to the functional unit. When more than one slot is ready, the oldest slot goes first, and a slot that has been dispatched is never sent again. A slot becomes free once the bus carries a result under that slot's own tag.

Tags are the slot numbers 1 to N, and tag 0 means "no producer". Tags above N belong to producers in other banks, and this bank only listens for them. If an operand's producer broadcasts in the same cycle as the issue, the broadcast value goes straight into the new slot.

Top module: `rs_bank`

## Requirements
- R1: After reset every slot is free: `iss_full_o` is 0, `disp_valid_o` is 0 and `iss_tag_o` is 1.
- R2: An issued operation whose operand tags are both 0 stores the given values. It appears on the dispatch port in the cycle after the issue edge, showing its tag, opcode and both values.
- R3: An operand issued with a non-zero tag is filled from the result bus at the first edge where `cdb_valid_i` is 1 and `cdb_tag_i` equals that tag. The slot is dispatched in the next cycle with the bus value in that operand position.
- R4: A slot with at least one non-zero operand tag is never presented on the dispatch port.
- R5: Tags run from 1 to N, and tag 0 means null. An issue takes the lowest-numbered free slot, and `iss_tag_o` always shows the tag the next issue would receive.
- R6: While all N slots are busy, `iss_full_o` is 1. An issue request in that state changes no slot.
- R7: A dispatched slot becomes free at the edge where the bus carries its own tag with `cdb_valid_i` set. From then on it can be allocated again.
- R8: When several slots are ready, the one issued earliest is dispatched first, whatever its slot number. After that, one slot is dispatched per cycle.
- R9: A slot is presented on the dispatch port for exactly one cycle, and after that it is executing until it is freed.
- R10: If an issued operand's tag equals `cdb_tag_i` while `cdb_valid_i` is 1 in the issue cycle, the slot stores the bus value and a null tag for that operand.
- R11: The result bus has no effect on a waiting operand when `cdb_valid_i` is 0 or when the tag differs from the operand's tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| iss_valid_i | input | 1 | Issue request |
| iss_op_i | input | OP_W | Opcode of the issued operation |
| iss_qj_i | input | TAG_W | Producer tag of the first operand; 0 means the value is given |
| iss_vj_i | input | DATA_W | First operand value, used when its tag is 0 |
| iss_qk_i | input | TAG_W | Producer tag of the second operand; 0 means the value is given |
| iss_vk_i | input | DATA_W | Second operand value, used when its tag is 0 |
| iss_full_o | output | 1 | All slots busy; an issue is refused |
| iss_tag_o | output | TAG_W | Tag the next accepted issue receives |
| cdb_valid_i | input | 1 | Result bus carries a result |
| cdb_tag_i | input | TAG_W | Tag of the producer of the broadcast result |
| cdb_val_i | input | DATA_W | Broadcast result value |
| disp_valid_o | output | 1 | A ready slot is sent to the functional unit this cycle |
| disp_tag_o | output | TAG_W | Tag of the dispatched slot |
| disp_op_o | output | OP_W | Opcode of the dispatched slot |
| disp_vj_o | output | DATA_W | First operand of the dispatched slot |
| disp_vk_o | output | DATA_W | Second operand of the dispatched slot |

## Verification
The assertions assume that the result bus carries this bank's own tag only for a slot that has already been dispatched. They also assume that the functional unit accepts every dispatch in the cycle it is presented. The stimulus respects both: it broadcasts a bank tag only after that slot's dispatch cycle has passed, and it never holds back a dispatch. External producers always use tags 5 to 7, which no slot of a four-entry bank owns. Each expected dispatch is queued before the stimulus that causes it, so both ordering and single dispatch are checked by the order in which the results come out.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EXEC = 2'd2
  } slot_st_e;
endpackage

// File: rtl/rsb_alloc.sv
module rsb_alloc #(
  parameter int N     = 4,
  parameter int IDX_W = 2,
  parameter int TAG_W = 3
) (
  input  logic [N-1:0]     busy_i,
  output logic [N-1:0]     grant_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             full_o
);
  logic [IDX_W-1:0] sel;
  logic             found;

  always_comb begin
    grant_o = '0;
    sel     = '0;
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!busy_i[i] && !found) begin
        grant_o[i] = 1'b1;
        sel        = IDX_W'(i);
        found      = 1'b1;
      end
    end
    full_o = ~found;
    tag_o  = TAG_W'(sel) + TAG_W'(1);
  end
endmodule

// File: rtl/rsb_pick.sv
module rsb_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2,
  parameter int AGE_W = 2
) (
  input  logic [N-1:0]            ready_i,
  input  logic [N-1:0][AGE_W-1:0] age_i,
  output logic [N-1:0]            grant_o,
  output logic [IDX_W-1:0]        sel_o,
  output logic                    valid_o
);
  logic [AGE_W-1:0] best;

  always_comb begin
    best    = '0;
    sel_o   = '0;
    valid_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (ready_i[i] && (!valid_o || age_i[i] > best)) begin
        best    = age_i[i];
        sel_o   = IDX_W'(i);
        valid_o = 1'b1;
      end
    end
    grant_o = '0;
    if (valid_o) grant_o[sel_o] = 1'b1;
  end
endmodule

// File: rtl/rsb_entry.sv
module rsb_entry
  import rsb_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 3,
  parameter int AGE_W  = 2,
  parameter int MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              iss_fire_i,
  input  logic [OP_W-1:0]   iss_op_i,
  input  logic [TAG_W-1:0]  iss_qj_i,
  input  logic [DATA_W-1:0] iss_vj_i,
  input  logic [TAG_W-1:0]  iss_qk_i,
  input  logic [DATA_W-1:0] iss_vk_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_val_i,
  input  logic              grant_i,
  input  logic              free_any_i,
  input  logic [AGE_W-1:0]  free_age_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic              release_o,
  output logic [AGE_W-1:0]  age_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] vj_o,
  output logic [DATA_W-1:0] vk_o
);
  localparam logic [TAG_W-1:0] OWN_TAG = TAG_W'(MY_TAG);

  slot_st_e          st_q, st_d;
  logic [TAG_W-1:0]  qj_q, qj_d, qk_q, qk_d;
  logic [AGE_W-1:0]  age_q, age_d;
  logic [OP_W-1:0]   op_q, op_d;
  logic [DATA_W-1:0] vj_q, vj_d, vk_q, vk_d;
  logic              hit_j, hit_k, older_gone, ld_en;

  assign hit_j      = cdb_valid_i && (qj_q != '0) && (cdb_tag_i == qj_q);
  assign hit_k      = cdb_valid_i && (qk_q != '0) && (cdb_tag_i == qk_q);
  assign release_o  = (st_q == ST_EXEC) && cdb_valid_i && (cdb_tag_i == OWN_TAG);
  assign older_gone = free_any_i && (free_age_i < age_q);
  assign ld_en      = alloc_i | hit_j | hit_k;

  always_comb begin
    st_d  = st_q;
    qj_d  = qj_q;
    qk_d  = qk_q;
    age_d = age_q;
    op_d  = op_q;
    vj_d  = vj_q;
    vk_d  = vk_q;
    if (alloc_i) begin
      st_d  = ST_WAIT;
      op_d  = iss_op_i;
      qj_d  = iss_qj_i;
      vj_d  = iss_vj_i;
      qk_d  = iss_qk_i;
      vk_d  = iss_vk_i;
      age_d = '0;
    end else if (st_q != ST_FREE) begin
      if (hit_j) begin
        qj_d = '0;
        vj_d = cdb_val_i;
      end
      if (hit_k) begin
        qk_d = '0;
        vk_d = cdb_val_i;
      end
      if (grant_i)   st_d = ST_EXEC;
      if (release_o) st_d = ST_FREE;
      age_d = age_q + AGE_W'(iss_fire_i) - AGE_W'(older_gone);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_FREE;
      qj_q  <= '0;
      qk_q  <= '0;
      age_q <= '0;
    end else begin
      st_q  <= st_d;
      qj_q  <= qj_d;
      qk_q  <= qk_d;
      age_q <= age_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      op_q <= op_d;
      vj_q <= vj_d;
      vk_q <= vk_d;
    end
  end

  assign busy_o  = (st_q != ST_FREE);
  assign ready_o = (st_q == ST_WAIT) && (qj_q == '0) && (qk_q == '0);
  assign age_o   = age_q;
  assign op_o    = op_q;
  assign vj_o    = vj_q;
  assign vk_o    = vk_q;

  AST_GRANT_NEEDS_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |-> (st_q == ST_WAIT && qj_q == '0 && qk_q == '0)); // R4
  AST_NO_REDISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXEC) |-> !grant_i); // R9
  AST_SNOOP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_FREE && !alloc_i && hit_j) |=> (qj_q == '0 && vj_q == $past(cdb_val_i))); // R3
  AST_OWN_TAG_AFTER_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_FREE && cdb_valid_i && cdb_tag_i == OWN_TAG) |-> (st_q == ST_EXEC)); // R7
  AST_ALLOC_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> (st_q == ST_FREE)); // R5
endmodule

// File: rtl/rs_bank.sv
module rs_bank #(
  parameter int N      = 4,
  parameter int OP_W   = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid_i,
  input  logic [OP_W-1:0]   iss_op_i,
  input  logic [TAG_W-1:0]  iss_qj_i,
  input  logic [DATA_W-1:0] iss_vj_i,
  input  logic [TAG_W-1:0]  iss_qk_i,
  input  logic [DATA_W-1:0] iss_vk_i,
  output logic              iss_full_o,
  output logic [TAG_W-1:0]  iss_tag_o,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_val_i,
  output logic              disp_valid_o,
  output logic [TAG_W-1:0]  disp_tag_o,
  output logic [OP_W-1:0]   disp_op_o,
  output logic [DATA_W-1:0] disp_vj_o,
  output logic [DATA_W-1:0] disp_vk_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int AGE_W = IDX_W;

  logic [N-1:0]            busy_vec, ready_vec, rel_vec, alloc_gnt, pick_gnt;
  logic [N-1:0][AGE_W-1:0] age_vec;
  logic [OP_W-1:0]         op_a [N];
  logic [DATA_W-1:0]       vj_a [N];
  logic [DATA_W-1:0]       vk_a [N];
  logic [IDX_W-1:0]        pick_sel;
  logic                    iss_fire, fwd_j, fwd_k, free_any;
  logic [TAG_W-1:0]        qj_in, qk_in;
  logic [DATA_W-1:0]       vj_in, vk_in;
  logic [AGE_W-1:0]        free_age;

  assign iss_fire = iss_valid_i & ~iss_full_o;
  assign fwd_j    = cdb_valid_i && (iss_qj_i != '0) && (cdb_tag_i == iss_qj_i);
  assign fwd_k    = cdb_valid_i && (iss_qk_i != '0) && (cdb_tag_i == iss_qk_i);
  assign qj_in    = fwd_j ? '0 : iss_qj_i;
  assign vj_in    = fwd_j ? cdb_val_i : iss_vj_i;
  assign qk_in    = fwd_k ? '0 : iss_qk_i;
  assign vk_in    = fwd_k ? cdb_val_i : iss_vk_i;

  always_comb begin
    free_age = '0;
    for (int i = 0; i < N; i++) begin
      if (rel_vec[i]) free_age = free_age | age_vec[i];
    end
  end
  assign free_any = |rel_vec;

  rsb_alloc #(.N(N), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_alloc (
    .busy_i  (busy_vec),
    .grant_o (alloc_gnt),
    .tag_o   (iss_tag_o),
    .full_o  (iss_full_o)
  );

  rsb_pick #(.N(N), .IDX_W(IDX_W), .AGE_W(AGE_W)) u_pick (
    .ready_i (ready_vec),
    .age_i   (age_vec),
    .grant_o (pick_gnt),
    .sel_o   (pick_sel),
    .valid_o (disp_valid_o)
  );

  for (genvar g = 0; g < N; g++) begin : g_slot
    rsb_entry #(
      .OP_W(OP_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .AGE_W(AGE_W), .MY_TAG(g + 1)
    ) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_i     (alloc_gnt[g] & iss_fire),
      .iss_fire_i  (iss_fire),
      .iss_op_i    (iss_op_i),
      .iss_qj_i    (qj_in),
      .iss_vj_i    (vj_in),
      .iss_qk_i    (qk_in),
      .iss_vk_i    (vk_in),
      .cdb_valid_i (cdb_valid_i),
      .cdb_tag_i   (cdb_tag_i),
      .cdb_val_i   (cdb_val_i),
      .grant_i     (pick_gnt[g]),
      .free_any_i  (free_any),
      .free_age_i  (free_age),
      .busy_o      (busy_vec[g]),
      .ready_o     (ready_vec[g]),
      .release_o   (rel_vec[g]),
      .age_o       (age_vec[g]),
      .op_o        (op_a[g]),
      .vj_o        (vj_a[g]),
      .vk_o        (vk_a[g])
    );
  end

  assign disp_tag_o = TAG_W'(pick_sel) + TAG_W'(1);
  assign disp_op_o  = op_a[pick_sel];
  assign disp_vj_o  = vj_a[pick_sel];
  assign disp_vk_o  = vk_a[pick_sel];

  for (genvar a = 0; a < N; a++) begin : g_age_a
    for (genvar b = a + 1; b < N; b++) begin : g_age_b
      AST_AGES_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_vec[a] && busy_vec[b]) |-> (age_vec[a] != age_vec[b])); // R8
    end
  end

  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid_i && iss_full_o && !free_any) |=> iss_full_o); // R6
  AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rel_vec)); // R7
endmodule

// File: tb/rs_bank_test.sv
module rs_bank_test;
  localparam int N = 4, OP_W = 4, DATA_W = 16, TAG_W = 3;
  localparam int ITEM_W = TAG_W + OP_W + 2 * DATA_W;

  logic clk = 1'b0;
  logic rst_n;
  logic iss_valid_i, cdb_valid_i;
  logic [OP_W-1:0] iss_op_i;
  logic [TAG_W-1:0] iss_qj_i, iss_qk_i, cdb_tag_i;
  logic [DATA_W-1:0] iss_vj_i, iss_vk_i, cdb_val_i;
  logic iss_full_o, disp_valid_o;
  logic [TAG_W-1:0] iss_tag_o, disp_tag_o;
  logic [OP_W-1:0] disp_op_o;
  logic [DATA_W-1:0] disp_vj_o, disp_vk_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [ITEM_W-1:0] exp_q[$];
  string req_q[$];

  always #4 clk = ~clk;

  rs_bank #(.N(N), .OP_W(OP_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid_i(iss_valid_i), .iss_op_i(iss_op_i),
    .iss_qj_i(iss_qj_i), .iss_vj_i(iss_vj_i), .iss_qk_i(iss_qk_i), .iss_vk_i(iss_vk_i),
    .iss_full_o(iss_full_o), .iss_tag_o(iss_tag_o),
    .cdb_valid_i(cdb_valid_i), .cdb_tag_i(cdb_tag_i), .cdb_val_i(cdb_val_i),
    .disp_valid_o(disp_valid_o), .disp_tag_o(disp_tag_o), .disp_op_o(disp_op_o),
    .disp_vj_o(disp_vj_o), .disp_vk_o(disp_vk_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_disp(input int tag, input int op, input int vj, input int vk, input string req);
    exp_q.push_back({TAG_W'(tag), OP_W'(op), DATA_W'(vj), DATA_W'(vk)});
    req_q.push_back(req);
  endtask

  task automatic set_iss(input int op, input int jt, input int jv, input int kt, input int kv);
    iss_valid_i = 1'b1;
    iss_op_i = OP_W'(op);
    iss_qj_i = TAG_W'(jt);
    iss_vj_i = DATA_W'(jv);
    iss_qk_i = TAG_W'(kt);
    iss_vk_i = DATA_W'(kv);
  endtask

  task automatic set_cdb(input bit v, input int tag, input int val);
    cdb_valid_i = v;
    cdb_tag_i = TAG_W'(tag);
    cdb_val_i = DATA_W'(val);
  endtask

  task automatic step();
    @(negedge clk);
    iss_valid_i = 1'b0;
    cdb_valid_i = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  // monitor: pops expected dispatches just before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rst_n === 1'b1 && disp_valid_o === 1'b1) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected dispatch", longint'({disp_tag_o, disp_op_o}), 0);
        end else begin
          logic [ITEM_W-1:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          chk({disp_tag_o, disp_op_o, disp_vj_o, disp_vk_o} === e, r,
              longint'({disp_tag_o, disp_op_o, disp_vj_o, disp_vk_o}), longint'(e));
        end
      end
    end
  end

  initial begin
    #(8 * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    iss_valid_i = 1'b0;
    cdb_valid_i = 1'b0;
    set_iss(0, 0, 0, 0, 0);
    iss_valid_i = 1'b0;
    set_cdb(1'b0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(iss_full_o == 1'b0, "R1 full", iss_full_o, 0);
    chk(disp_valid_o == 1'b0, "R1 disp_valid", disp_valid_o, 0);
    chk(iss_tag_o == 3'd1, "R1 iss_tag", iss_tag_o, 1);

    // ready operands, single dispatch, release
    expect_disp(1, 3, 10, 20, "R2 ready issue");
    set_iss(3, 0, 10, 0, 20);
    step();
    chk(iss_tag_o == 3'd2, "R5 next tag", iss_tag_o, 2);
    step();
    chk(disp_valid_o == 1'b0, "R9 executing not resent", disp_valid_o, 0);
    step();
    set_cdb(1'b1, 1, 99);
    step();
    chk(iss_tag_o == 3'd1, "R7 slot freed", iss_tag_o, 1);

    // snoop capture and ignored broadcasts
    set_iss(5, 6, 0, 0, 7);
    step();
    step();
    chk(disp_valid_o == 1'b0, "R4 waiting operand", disp_valid_o, 0);
    set_cdb(1'b1, 5, 1);
    step();
    step();
    chk(disp_valid_o == 1'b0, "R11 tag mismatch", disp_valid_o, 0);
    set_cdb(1'b0, 6, 123);
    step();
    step();
    chk(disp_valid_o == 1'b0, "R11 bus not valid", disp_valid_o, 0);
    expect_disp(1, 5, 44, 7, "R3 captured operand");
    set_cdb(1'b1, 6, 44);
    step();
    step();
    set_cdb(1'b1, 1, 0);
    step();

    // same-cycle forwarding
    expect_disp(1, 2, 55, 3, "R10 forward at issue");
    set_iss(2, 7, 0, 0, 3);
    set_cdb(1'b1, 7, 55);
    step();
    step();
    set_cdb(1'b1, 1, 0);
    step();

    // fill, refuse, oldest-first
    set_iss(1, 5, 0, 0, 1); step();
    set_iss(2, 6, 0, 0, 2); step();
    set_iss(3, 5, 0, 0, 3); step();
    set_iss(4, 5, 0, 0, 4); step();
    chk(iss_full_o == 1'b1, "R6 full", iss_full_o, 1);
    set_iss(9, 0, 1, 0, 1);
    step();
    chk(iss_full_o == 1'b1, "R6 refused issue", iss_full_o, 1);
    expect_disp(1, 1, 100, 1, "R8 oldest first");
    expect_disp(3, 3, 100, 3, "R8 second oldest");
    expect_disp(4, 4, 100, 4, "R8 third oldest");
    set_cdb(1'b1, 5, 100);
    step(); step(); step(); step();
    expect_disp(2, 2, 200, 2, "R3 late operand");
    set_cdb(1'b1, 6, 200);
    step(); step(); step();
    set_cdb(1'b1, 3, 0);
    step();
    chk(iss_tag_o == 3'd3, "R7 freed slot 3", iss_tag_o, 3);
    chk(iss_full_o == 1'b0, "R6 not full", iss_full_o, 0);
    set_iss(7, 5, 0, 0, 7);
    step();
    set_cdb(1'b1, 1, 0);
    step();
    chk(iss_tag_o == 3'd1, "R5 lowest free", iss_tag_o, 1);
    set_iss(8, 5, 0, 0, 8);
    step();
    expect_disp(3, 7, 9, 7, "R8 age beats index");
    expect_disp(1, 8, 9, 8, "R8 younger slot");
    set_cdb(1'b1, 5, 9);
    step(); step(); step(); step();
    set_cdb(1'b1, 2, 0); step();
    set_cdb(1'b1, 4, 0); step();
    set_cdb(1'b1, 3, 0); step();
    set_cdb(1'b1, 1, 0); step();
    step();
    chk(iss_full_o == 1'b0, "R7 all freed", iss_full_o, 0);
    chk(iss_tag_o == 3'd1, "R5 back to first", iss_tag_o, 1);
    chk(exp_q.size() == 0, "R9 all dispatches seen", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule